// File: doc/BRIEF.md
# Word Boundary Aligner with Pattern Hunt and Bit Slip

This block recovers word boundaries from a parallel stream built from a serial line. Each clock it takes one raw word (bit 0 is the earliest received bit) and keeps the previous word. The two words form a window of twice the word width, and the block selects one word-wide slice of that window at a bit offset from 0 to W-1. It then registers the slice as the realigned output, together with a flag that the output starts with the alignment pattern and a status that the boundary is locked.

There are two control modes. In hunt mode, raising the search enable starts a search for a programmable alignment pattern. The block locks on the lowest offset where the pattern is found and freezes that offset until the enable is dropped and raised again. In slip mode, each rising edge of the slip input moves the boundary one bit later, which drops the oldest bit from the output. A separate monitor counts runs of identical bits across word boundaries and raises a sticky flag when a run exceeds a programmable limit.

Top module: `word_aligner`

## Requirements
- R1: After reset the output word is 0, the pattern flag, aligned status and run-length flag are 0, and the offset is 0.
- R2: At each clock edge the output becomes bits [k+W-1:k] of the window {din, previous din}, where k is the offset selected at that edge. With offset 0 the output is the previous input word unchanged.
- R3: In hunt mode (mode=0) with search enabled and not aligned, if the pattern matches window bits [k+P-1:k] for some k in 0..W-1, the lowest such k becomes the offset at that same edge and aligned rises.
- R4: While aligned and the search enable stays high in hunt mode, the offset does not change, even if the pattern appears at another position. Dropping the enable clears aligned and keeps the offset. Raising it again starts a new search.
- R5: The pattern flag is 1 exactly when the low P bits of the output word equal the pattern (P is the pattern length, one of 7, 8, 10, 16, 20, 32, not above W).
- R6: In slip mode (mode=1) each rising edge of the slip input increases the offset by one, so the earliest bit is dropped. A slip input held high produces only one slip. Aligned is 0 in slip mode.
- R7: The slip offset wraps from W-1 to 0.
- R8: With run checking enabled, the run-length flag is set when a run of equal consecutive bits, counted across word boundaries, becomes longer than the limit (intended range 40 to 640). A run equal to the limit does not set it.
- R9: The run-length flag stays set until the clear input is high at a clock edge. With run checking disabled, no run sets the flag.
- R10: In hunt mode the slip input has no effect on the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | W | Raw received word, bit 0 earliest |
| mode | input | 1 | 0 = pattern hunt, 1 = bit slip |
| search_en | input | 1 | Starts or holds the pattern hunt |
| pattern | input | P | Alignment pattern, bit 0 earliest |
| slip | input | 1 | Slip request, acts on its rising edge |
| rl_en | input | 1 | Enables run-length checking |
| rl_limit | input | CW | Longest legal run of equal bits |
| rl_clear | input | 1 | Clears the run-length flag |
| dout | output | W | Realigned word |
| pat_det | output | 1 | Output word begins with the pattern |
| aligned | output | 1 | Boundary locked by the hunt |
| rl_viol | output | 1 | Sticky run-length violation flag |

## Verification
The assertions assume that the mode input is held steady across the slip pulses they reason about. They also assume that the clear input does not go high in the same cycle as a new violation, because in that cycle the set would win over the clear and the sticky property would not apply. The stimulus keeps within this: it changes the mode only between test phases while slip is low, and it raises the clear only on words that cannot extend an over-long run. It uses a fixed run limit of 40 and places the pattern at chosen window offsets so that each lock position is known in advance.

// File: rtl/wa_pkg.sv
package wa_pkg;
    typedef enum logic {
        MODE_HUNT = 1'b0,
        MODE_SLIP = 1'b1
    } wa_mode_e;
endpackage

// File: rtl/wa_window_mux.sv
module wa_window_mux #(
    parameter int W     = 10,
    parameter int OFF_W = $clog2(W)
) (
    input  logic [2*W-1:0]   win,
    input  logic [OFF_W-1:0] sel,
    output logic [W-1:0]     word
);
    logic [W-1:0] taps [W];

    for (genvar k = 0; k < W; k++) begin : g_tap
        assign taps[k] = win[k +: W];
    end

    always_comb begin
        word = taps[0];
        for (int k = 0; k < W; k++) begin
            if (32'(sel) == k) word = taps[k];
        end
    end
endmodule

// File: rtl/wa_pattern_finder.sv
module wa_pattern_finder #(
    parameter int W     = 10,
    parameter int P     = 10,
    parameter int OFF_W = $clog2(W)
) (
    input  logic [2*W-1:0]   win,
    input  logic [P-1:0]     pattern,
    output logic             hit,
    output logic [OFF_W-1:0] idx
);
    logic [W-1:0] match;

    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign match[k] = (win[k +: P] == pattern);
    end

    always_comb begin
        idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (match[k]) idx = OFF_W'(k);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/wa_run_monitor.sv
module wa_run_monitor #(
    parameter int W    = 10,
    parameter int CW   = 10
) (
    input  logic [W-1:0]  bits,
    input  logic          last_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [CW-1:0] limit,
    output logic          last_out,
    output logic [CW-1:0] cnt_out,
    output logic          over
);
    always_comb begin
        last_out = last_in;
        cnt_out  = cnt_in;
        over     = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (bits[i] == last_out) begin
                if (cnt_out != '1) cnt_out = cnt_out + 1'b1;
            end else begin
                cnt_out = CW'(1);
            end
            last_out = bits[i];
            if (cnt_out > limit) over = 1'b1;
        end
    end
endmodule

// File: rtl/word_aligner.sv
module word_aligner
    import wa_pkg::*;
#(
    parameter int W      = 10,
    parameter int P      = 10,
    parameter int RL_MAX = 640,
    localparam int OFF_W = $clog2(W),
    localparam int CW    = $clog2(RL_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic          mode,
    input  logic          search_en,
    input  logic [P-1:0]  pattern,
    input  logic          slip,
    input  logic          rl_en,
    input  logic [CW-1:0] rl_limit,
    input  logic          rl_clear,
    output logic [W-1:0]  dout,
    output logic          pat_det,
    output logic          aligned,
    output logic          rl_viol
);
    typedef struct packed {
        logic [W-1:0]     prev;
        logic [OFF_W-1:0] off;
        logic             locked;
        logic             slip_q;
        logic [W-1:0]     dout;
        logic             pat;
        logic             last;
        logic [CW-1:0]    cnt;
        logic             viol;
    } st_t;

    st_t st_q, st_d;

    logic [2*W-1:0]   win;
    logic             hit;
    logic [OFF_W-1:0] hit_idx;
    logic [OFF_W-1:0] sel_d;
    logic             lock_d;
    logic [W-1:0]     word_d;
    logic             rl_last_d;
    logic [CW-1:0]    rl_cnt_d;
    logic             rl_over;
    wa_mode_e         mode_e;

    assign win    = {din, st_q.prev};
    assign mode_e = wa_mode_e'(mode);

    wa_pattern_finder #(.W(W), .P(P), .OFF_W(OFF_W)) u_find (
        .win     (win),
        .pattern (pattern),
        .hit     (hit),
        .idx     (hit_idx)
    );

    always_comb begin
        sel_d  = st_q.off;
        lock_d = st_q.locked;
        if (mode_e == MODE_SLIP) begin
            lock_d = 1'b0;
            if (slip && !st_q.slip_q) begin
                sel_d = (32'(st_q.off) == W - 1) ? '0 : st_q.off + OFF_W'(1);
            end
        end else if (!search_en) begin
            lock_d = 1'b0;
        end else if (!st_q.locked && hit) begin
            sel_d  = hit_idx;
            lock_d = 1'b1;
        end
    end

    wa_window_mux #(.W(W), .OFF_W(OFF_W)) u_mux (
        .win  (win),
        .sel  (sel_d),
        .word (word_d)
    );

    wa_run_monitor #(.W(W), .CW(CW)) u_run (
        .bits     (din),
        .last_in  (st_q.last),
        .cnt_in   (st_q.cnt),
        .limit    (rl_limit),
        .last_out (rl_last_d),
        .cnt_out  (rl_cnt_d),
        .over     (rl_over)
    );

    always_comb begin
        st_d        = st_q;
        st_d.prev   = din;
        st_d.slip_q = slip;
        st_d.off    = sel_d;
        st_d.locked = lock_d;
        st_d.dout   = word_d;
        st_d.pat    = (word_d[P-1:0] == pattern);
        st_d.last   = rl_last_d;
        st_d.cnt    = rl_cnt_d;
        st_d.viol   = (st_q.viol & ~rl_clear) | (rl_en & rl_over);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign pat_det = st_q.pat;
    assign aligned = st_q.locked;
    assign rl_viol = st_q.viol;
endmodule

// File: rtl/wa_checker.sv
module wa_checker #(
    parameter int W     = 10,
    parameter int OFF_W = $clog2(W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode,
    input logic             search_en,
    input logic             slip,
    input logic             rl_clear,
    input logic             aligned,
    input logic             pat_det,
    input logic             rl_viol,
    input logic [OFF_W-1:0] offset
);
    logic slip_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) slip_prev <= 1'b0;
        else        slip_prev <= slip;
    end

    p_lock_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> pat_det);

    p_offset_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && search_en && !mode) |=> $stable(offset));

    p_slip_unaligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode |=> !aligned);

    p_slip_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && slip && !slip_prev) |=>
        (offset == ((32'($past(offset)) == W - 1) ? '0 : $past(offset) + OFF_W'(1))));

    p_slip_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !(slip && !slip_prev)) |=> $stable(offset));

    p_hunt_noslip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !search_en) |=> $stable(offset));

    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_viol && !rl_clear) |=> rl_viol);

    p_offset_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(offset) < W);
endmodule

bind word_aligner wa_checker #(.W(W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .search_en (search_en),
    .slip      (slip),
    .rl_clear  (rl_clear),
    .aligned   (aligned),
    .pat_det   (pat_det),
    .rl_viol   (rl_viol),
    .offset    (st_q.off)
);

// File: tb/word_aligner_tb.sv
module word_aligner_tb;
    localparam int W  = 10;
    localparam int P  = 10;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  din = '0;
    logic          mode = 1'b0;
    logic          search_en = 1'b0;
    logic [P-1:0]  pattern = 10'b0011111010;
    logic          slip = 1'b0;
    logic          rl_en = 1'b0;
    logic [CW-1:0] rl_limit = CW'(40);
    logic          rl_clear = 1'b0;
    logic [W-1:0]  dout;
    logic          pat_det, aligned, rl_viol;

    always #5 clk = ~clk;

    word_aligner #(.W(W), .P(P), .RL_MAX(640)) u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .mode(mode), .search_en(search_en),
        .pattern(pattern), .slip(slip), .rl_en(rl_en), .rl_limit(rl_limit),
        .rl_clear(rl_clear), .dout(dout), .pat_det(pat_det), .aligned(aligned),
        .rl_viol(rl_viol)
    );

    typedef struct {
        logic [W-1:0] dout;
        logic         pat;
        logic         algn;
        logic         viol;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // reference state, from the requirements
    logic [W-1:0] m_prev = '0;
    int           m_off = 0;
    bit           m_lock = 0;
    bit           m_slipq = 0;
    bit           m_last = 0;
    int           m_cnt = 0;
    bit           m_viol = 0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] d, input bit md, input bit se, input bit sl,
                         input bit rle, input bit rlc, input string tag);
        logic [2*W-1:0] w;
        int   sel;
        bit   lk;
        bit   ov;
        exp_t e;
        @(negedge clk);
        din = d; mode = md; search_en = se; slip = sl; rl_en = rle; rl_clear = rlc;
        w   = {d, m_prev};
        sel = m_off;
        lk  = m_lock;
        if (md) begin
            lk = 0;
            if (sl && !m_slipq) sel = (m_off + 1) % W;
        end else if (!se) begin
            lk = 0;
        end else if (!m_lock) begin
            for (int k = W - 1; k >= 0; k--)
                if (w[k +: P] == pattern) begin sel = k; lk = 1; end
        end
        ov = 0;
        for (int i = 0; i < W; i++) begin
            if (d[i] == m_last) m_cnt = m_cnt + 1; else m_cnt = 1;
            m_last = d[i];
            if (m_cnt > int'(rl_limit)) ov = 1;
        end
        m_viol  = (m_viol && !rlc) || (rle && ov);
        m_prev  = d;
        m_off   = sel;
        m_lock  = lk;
        m_slipq = sl;
        e.dout = w[sel +: W];
        e.pat  = (e.dout[P-1:0] == pattern);
        e.algn = lk;
        e.viol = m_viol;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " dout (R2)"}, dout, e.dout);
            check({e.tag, " pat_det (R5)"}, W'(pat_det), W'(e.pat));
            check({e.tag, " aligned"}, W'(aligned), W'(e.algn));
            check({e.tag, " rl_viol (R8/R9)"}, W'(rl_viol), W'(e.viol));
        end
    end

    // place the pattern at window offset k, send the two words
    task automatic send_pat(input int k, input bit se_first, input bit se_second, input string tag);
        logic [2*W-1:0] w;
        w = {$urandom, $urandom};
        w[k +: P] = pattern;
        drive(w[W-1:0], 0, se_first, 0, 0, 0, tag);
        drive(w[2*W-1:W], 0, se_second, 0, 0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 dout", dout, '0);
        check("R1 flags", W'({pat_det, aligned, rl_viol}), '0);

        // R2: offset 0, hunt idle
        for (int i = 0; i < 6; i++) drive(W'($urandom), 0, 0, 0, 0, 0, "R2 idle");

        // R3: lock at offset 3
        send_pat(3, 0, 1, "R3 lock3");
        // R4: frozen while enable held, pattern at another offset ignored
        for (int i = 0; i < 3; i++) drive(W'($urandom), 0, 1, 0, 0, 0, "R4 hold");
        send_pat(6, 1, 1, "R4 moved pattern");
        drive(W'($urandom), 0, 0, 0, 0, 0, "R4 drop");
        drive(W'($urandom), 0, 0, 0, 0, 0, "R4 idle");
        send_pat(7, 0, 1, "R3 relock7");
        drive(W'($urandom), 0, 1, 0, 0, 0, "R4 hold7");
        send_pat(0, 0, 0, "R3 pattern no enable");

        // R6: slip mode, held level gives one slip
        drive(W'($urandom), 1, 0, 0, 0, 0, "R6 enter slip");
        for (int i = 0; i < 3; i++) drive(W'($urandom), 1, 0, 1, 0, 0, "R6 held");
        drive(W'($urandom), 1, 0, 0, 0, 0, "R6 low");
        // R7: pulses past W-1 to wrap
        for (int i = 0; i < W + 2; i++) begin
            drive(W'($urandom), 1, 0, 1, 0, 0, "R7 pulse");
            drive(W'($urandom), 1, 0, 0, 0, 0, "R7 gap");
        end

        // R10: slip ignored in hunt mode
        drive(W'($urandom), 0, 0, 0, 0, 0, "R10 hunt");
        for (int i = 0; i < 4; i++) begin
            drive(W'($urandom), 0, 0, 1, 0, 0, "R10 slip high");
            drive(W'($urandom), 0, 0, 0, 0, 0, "R10 slip low");
        end

        // R8: run of exactly 40 zeros is legal, 41 is not
        drive('1, 0, 0, 0, 1, 0, "R8 ones");
        for (int i = 0; i < 4; i++) drive('0, 0, 0, 0, 1, 0, "R8 run40");
        drive('1, 0, 0, 0, 1, 0, "R8 end40");
        for (int i = 0; i < 4; i++) drive('0, 0, 0, 0, 1, 0, "R8 run41");
        drive(10'b1111111110, 0, 0, 0, 1, 0, "R8 hit41");
        // R9: sticky, then cleared
        for (int i = 0; i < 3; i++) drive(10'b1010101010, 0, 0, 0, 1, 0, "R9 sticky");
        drive(10'b0101010101, 0, 0, 0, 1, 1, "R9 clear");
        drive(10'b1010101010, 0, 0, 0, 1, 0, "R9 cleared");
        // R9: disabled checking ignores a long run of ones
        for (int i = 0; i < 8; i++) drive('1, 0, 0, 0, 0, 0, "R9 disabled");
        drive(10'b0101010101, 0, 0, 0, 0, 0, "R9 disabled end");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule